// File: doc/BRIEF.md
# Timed Control Command Parser

This block reads a control payload from the host as a stream of 32-bit words and carries out the operations it contains. The payload holds commands that take effect only at a given time. The first word of each packet is a timestamp on the shared sample-time counter. Each word after it begins one operation: a header, followed by as many argument words as the header states. The block decodes each operation. It holds the operation until the sample counter has reached the packet's timestamp, and then dispatches it to one of two back ends.

A register-write operation produces a single-cycle strobe on an internal register bus. The four serial operations (I2C write, I2C read, SPI write, SPI read) produce a request towards an external serial master engine through a valid/ready handshake. After the engine accepts a request, the block waits for the engine's completion pulse. For a read, the returned data goes to the host as a reply word on a valid/ready reply port.

Back-pressure rules are as follows. `in_ready` is high only while the block is collecting a timestamp, a header or an argument. It stays low while an operation is waiting for its time, while a serial request is pending or executing, and while a reply is waiting to be taken. A request and a reply, once offered, stay asserted and unchanged until their ready input is seen high at a clock edge.

Top module: `timed_cmd_parser`

## Requirements
- R1: Reset state. While `rst_n` is low and afterwards, until the first input arrives: `in_ready` is 1; `reg_wr_en`, `ser_req_valid`, `rpl_valid` and `err_sticky` are 0.
- R2: Packet framing.
  - The first word accepted after reset, or after a word that carried `in_last`, is the packet timestamp.
  - Every later word that starts an operation is a header, with the opcode in bits [31:24] and the argument count in bits [7:0].
  - A known operation whose timestamp is in the future dispatches on exactly the clock edge at which `now_time` equals that timestamp.
- R3: Time gate.
  - An operation is dispatched only at an edge where `now_time - timestamp`, taken as a signed 32-bit value, is zero or positive.
  - A timestamp that is already in the past, including one that is behind the counter across a wrap, dispatches without waiting.
- R4: Register write. Opcode 0x01 with arguments (address, data) gives a one-cycle `reg_wr_en` pulse, starting one cycle after the dispatch edge.
  - `reg_addr` equals the low ADDR_W bits of the first argument.
  - `reg_wdata` equals the second argument.
- R5: Serial request. The serial opcodes are 0x02 (I2C write), 0x03 (I2C read), 0x04 (SPI write) and 0x05 (SPI read).
  - Each raises `ser_req_valid`, which holds until `ser_req_ready` is seen high.
  - `ser_req_spi` is 1 for SPI. `ser_req_rd` is 1 for reads.
  - `ser_req_addr` is the first argument.
  - `ser_req_data` is the second argument for writes and 0 for reads.
- R6: Reply. After a read request is accepted, the block waits for `ser_done_valid`. It then offers `rpl_data = {opcode, ser_done_data}` on `rpl_valid`, held stable until `rpl_ready`.
- R7: Unknown opcodes.
  - An unknown opcode has its argument words consumed and discarded, with no output.
  - It sets `err_sticky`, which stays 1 until reset.
- R8: `in_ready` is 0 from the end of an operation's arguments until that operation has fully completed, including its serial request and its reply.
- R9: Argument handling.
  - Arguments beyond the second are consumed and ignored.
  - Missing arguments read as 0.
  - A word with `in_last` ends both the operation and the packet early.
- R10: Operations run strictly in stream order, with at most one of register strobe, serial request and reply active at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_time | input | TIME_W | Shared sample-time counter |
| in_valid | input | 1 | Payload word valid |
| in_ready | output | 1 | Payload word accepted when high with in_valid |
| in_data | input | 32 | Payload word |
| in_last | input | 1 | Last word of the packet |
| reg_wr_en | output | 1 | Register bus write strobe |
| reg_addr | output | ADDR_W | Register bus address |
| reg_wdata | output | 32 | Register bus write data |
| ser_req_valid | output | 1 | Serial request valid |
| ser_req_ready | input | 1 | Serial engine accepts request |
| ser_req_spi | output | 1 | 1 = SPI engine, 0 = I2C engine |
| ser_req_rd | output | 1 | 1 = read, 0 = write |
| ser_req_addr | output | 32 | Serial target address/command |
| ser_req_data | output | 32 | Serial write data (0 for reads) |
| ser_done_valid | input | 1 | Serial engine completion pulse |
| ser_done_data | input | 24 | Serial read result |
| rpl_valid | output | 1 | Reply word valid |
| rpl_ready | input | 1 | Host takes reply word |
| rpl_data | output | 32 | Reply: opcode in [31:24], result in [23:0] |
| err_sticky | output | 1 | Unknown opcode seen since reset |

## Verification
Timestamps are placed in the future, in the past, and on both sides of a counter wrap. A future stamp tells an exact-edge dispatch apart from an early or a late one. A stamp behind the counter across a wrap separates a signed comparison from an unsigned one. Random packets mix all five opcodes with random extra arguments, random serial-engine latency and random reply stalls, which separates strict ordering and held handshakes from dropped or reordered actions. Directed packets with an unknown opcode whose arguments look like headers, short argument lists and an early `in_last` show whether words are skipped, zero-filled and reframed correctly.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  localparam logic [7:0] OP_REG_WR = 8'h01;
  localparam logic [7:0] OP_I2C_WR = 8'h02;
  localparam logic [7:0] OP_I2C_RD = 8'h03;
  localparam logic [7:0] OP_SPI_WR = 8'h04;
  localparam logic [7:0] OP_SPI_RD = 8'h05;

  localparam int WORD_W  = 32;
  localparam int OPC_W   = 8;
  localparam int RES_W   = WORD_W - OPC_W;
  localparam int NARG    = 2;
  localparam int IDX_W   = $clog2(NARG + 1);

  typedef enum logic [2:0] {
    ST_STAMP, ST_HEAD, ST_ARG, ST_HOLD, ST_REQ, ST_RESP, ST_REPLY
  } state_t;

  typedef struct packed {
    logic known;
    logic is_reg;
    logic spi;
    logic rd;
  } op_class_t;
endpackage

// File: rtl/tcp_op_decode.sv
module tcp_op_decode
  import tcp_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output op_class_t        cls
);
  always_comb begin
    cls = '0;
    unique case (opcode)
      OP_REG_WR: begin cls.known = 1'b1; cls.is_reg = 1'b1; end
      OP_I2C_WR: begin cls.known = 1'b1; end
      OP_I2C_RD: begin cls.known = 1'b1; cls.rd = 1'b1; end
      OP_SPI_WR: begin cls.known = 1'b1; cls.spi = 1'b1; end
      OP_SPI_RD: begin cls.known = 1'b1; cls.spi = 1'b1; cls.rd = 1'b1; end
      default:   cls = '0;
    endcase
  end
endmodule

// File: rtl/tcp_time_gate.sv
module tcp_time_gate #(
  parameter int TIME_W = 32
) (
  input  logic [TIME_W-1:0] now_time,
  input  logic [TIME_W-1:0] target,
  output logic              due
);
  logic [TIME_W-1:0] diff;
  always_comb begin
    diff = now_time - target;
    due  = ~diff[TIME_W-1];
  end
endmodule

// File: rtl/timed_cmd_parser.sv
module timed_cmd_parser
  import tcp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int TIME_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TIME_W-1:0]   now_time,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_data,
  input  logic                in_last,
  output logic                reg_wr_en,
  output logic [ADDR_W-1:0]   reg_addr,
  output logic [WORD_W-1:0]   reg_wdata,
  output logic                ser_req_valid,
  input  logic                ser_req_ready,
  output logic                ser_req_spi,
  output logic                ser_req_rd,
  output logic [WORD_W-1:0]   ser_req_addr,
  output logic [WORD_W-1:0]   ser_req_data,
  input  logic                ser_done_valid,
  input  logic [RES_W-1:0]    ser_done_data,
  output logic                rpl_valid,
  input  logic                rpl_ready,
  output logic [WORD_W-1:0]   rpl_data,
  output logic                err_sticky
);
  state_t             state_q, after_op;
  logic [TIME_W-1:0]  stamp_q;
  logic [OPC_W-1:0]   op_q;
  logic [7:0]         left_q;
  logic [IDX_W-1:0]   idx_q;
  logic [WORD_W-1:0]  arg_q [NARG];
  logic               end_q;
  logic [WORD_W-1:0]  rpl_q;
  logic               due;
  logic               take;
  op_class_t          cls;

  tcp_op_decode u_dec (.opcode(op_q), .cls(cls));

  tcp_time_gate #(.TIME_W(TIME_W)) u_gate (
    .now_time(now_time), .target(stamp_q), .due(due));

  assign in_ready = (state_q == ST_STAMP) || (state_q == ST_HEAD) || (state_q == ST_ARG);
  assign take     = in_valid && in_ready;
  assign after_op = end_q ? ST_STAMP : ST_HEAD;

  assign ser_req_valid = (state_q == ST_REQ);
  assign ser_req_spi   = cls.spi;
  assign ser_req_rd    = cls.rd;
  assign ser_req_addr  = arg_q[0];
  assign ser_req_data  = cls.rd ? '0 : arg_q[1];
  assign rpl_valid     = (state_q == ST_REPLY);
  assign rpl_data      = rpl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_STAMP;
      stamp_q    <= '0;
      op_q       <= '0;
      left_q     <= '0;
      idx_q      <= '0;
      end_q      <= 1'b0;
      rpl_q      <= '0;
      err_sticky <= 1'b0;
      reg_wr_en  <= 1'b0;
      reg_addr   <= '0;
      reg_wdata  <= '0;
      for (int k = 0; k < NARG; k++) arg_q[k] <= '0;
    end else begin
      reg_wr_en <= 1'b0;
      unique case (state_q)
        ST_STAMP: if (take) begin
          stamp_q <= in_data[TIME_W-1:0];
          state_q <= in_last ? ST_STAMP : ST_HEAD;
        end
        ST_HEAD: if (take) begin
          op_q   <= in_data[WORD_W-1 -: OPC_W];
          left_q <= in_data[7:0];
          idx_q  <= '0;
          end_q  <= in_last;
          for (int k = 0; k < NARG; k++) arg_q[k] <= '0;
          state_q <= (in_data[7:0] == 8'd0 || in_last) ? ST_HOLD : ST_ARG;
        end
        ST_ARG: if (take) begin
          for (int k = 0; k < NARG; k++)
            if (idx_q == IDX_W'(k)) arg_q[k] <= in_data;
          if (idx_q < IDX_W'(NARG)) idx_q <= idx_q + 1'b1;
          left_q <= left_q - 8'd1;
          end_q  <= in_last;
          if (left_q == 8'd1 || in_last) state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (!cls.known) begin
            err_sticky <= 1'b1;
            state_q    <= after_op;
          end else if (due) begin
            if (cls.is_reg) begin
              reg_wr_en <= 1'b1;
              reg_addr  <= arg_q[0][ADDR_W-1:0];
              reg_wdata <= arg_q[1];
              state_q   <= after_op;
            end else begin
              state_q <= ST_REQ;
            end
          end
        end
        ST_REQ: if (ser_req_ready) state_q <= ST_RESP;
        ST_RESP: if (ser_done_valid) begin
          if (cls.rd) begin
            rpl_q   <= {op_q, ser_done_data};
            state_q <= ST_REPLY;
          end else begin
            state_q <= after_op;
          end
        end
        ST_REPLY: if (rpl_ready) state_q <= after_op;
        default: state_q <= ST_STAMP;
      endcase
    end
  end
endmodule

// File: rtl/tcp_checker.sv
module tcp_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              reg_wr_en,
  input logic              ser_req_valid,
  input logic              ser_req_ready,
  input logic              ser_req_spi,
  input logic              ser_req_rd,
  input logic [31:0]       ser_req_addr,
  input logic              rpl_valid,
  input logic              rpl_ready,
  input logic [31:0]       rpl_data,
  input logic              err_sticky,
  input logic              gate_due
);
  AST_WR_ONLY_WHEN_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> $past(gate_due)); // R3
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en); // R4
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ser_req_valid && !ser_req_ready |=> ser_req_valid && $stable(ser_req_addr)
      && $stable(ser_req_spi) && $stable(ser_req_rd)); // R5
  AST_RPL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rpl_valid && !rpl_ready |=> rpl_valid && $stable(rpl_data)); // R6
  AST_ERR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky); // R7
  AST_NO_INPUT_IN_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_req_valid || rpl_valid) |-> !in_ready); // R8
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr_en, ser_req_valid, rpl_valid})); // R10
endmodule

bind timed_cmd_parser tcp_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .reg_wr_en(reg_wr_en),
  .ser_req_valid(ser_req_valid), .ser_req_ready(ser_req_ready),
  .ser_req_spi(ser_req_spi), .ser_req_rd(ser_req_rd), .ser_req_addr(ser_req_addr),
  .rpl_valid(rpl_valid), .rpl_ready(rpl_ready), .rpl_data(rpl_data),
  .err_sticky(err_sticky), .gate_due(due));

// File: tb/tb_timed_cmd_parser.sv
module tb_timed_cmd_parser;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] now_time = 32'd0;
  logic        now_load = 1'b0;
  logic [31:0] now_val = 32'd0;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic [31:0] in_data = 32'd0;
  logic        in_ready;
  logic        reg_wr_en;
  logic [15:0] reg_addr;
  logic [31:0] reg_wdata;
  logic        ser_req_valid, ser_req_spi, ser_req_rd;
  logic        ser_req_ready = 1'b0;
  logic [31:0] ser_req_addr, ser_req_data;
  logic        ser_done_valid = 1'b0;
  logic [23:0] ser_done_data = 24'd0;
  logic        rpl_valid;
  logic        rpl_ready = 1'b0;
  logic [31:0] rpl_data;
  logic        err_sticky;

  timed_cmd_parser dut (
    .clk(clk), .rst_n(rst_n), .now_time(now_time),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ser_req_valid(ser_req_valid), .ser_req_ready(ser_req_ready),
    .ser_req_spi(ser_req_spi), .ser_req_rd(ser_req_rd),
    .ser_req_addr(ser_req_addr), .ser_req_data(ser_req_data),
    .ser_done_valid(ser_done_valid), .ser_done_data(ser_done_data),
    .rpl_valid(rpl_valid), .rpl_ready(rpl_ready), .rpl_data(rpl_data),
    .err_sticky(err_sticky));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) now_time <= now_load ? now_val : now_time + 32'd1;

  typedef struct {
    int          kind;   // 0 register write, 1 serial request, 2 reply
    logic [31:0] a;
    logic [31:0] d;
    logic        spi;
    logic        rd;
    logic [31:0] ts;
    bit          exact;
    bit          frame;
    bit          lim_en;
    logic [31:0] lim;
    bit          r9;
  } ev_t;

  ev_t         exp_q[$];
  int          checks = 0, fails = 0, r8_bad = 0;
  logic [31:0] pw [0:63];
  int          pn;
  logic [31:0] cur_ts;
  bit          first_ev;
  bit          nx_exact, nx_frame, nx_lim_en, nx_r9;
  logic [31:0] nx_lim;
  bit          prev_sv = 1'b0;

  function automatic logic [23:0] resp_fn(logic [31:0] a);
    return a[23:0] ^ {a[7:0], a[15:8], a[23:16]} ^ 24'h5A3C96;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic add_ev(int kind, logic [31:0] a, logic [31:0] d, logic spi, logic rd);
    ev_t e;
    e.kind = kind; e.a = a; e.d = d; e.spi = spi; e.rd = rd; e.ts = cur_ts;
    e.exact = first_ev && nx_exact; e.frame = first_ev && nx_frame;
    e.lim_en = first_ev && nx_lim_en; e.lim = nx_lim; e.r9 = nx_r9;
    first_ev = 1'b0;
    exp_q.push_back(e);
  endtask

  task automatic pk_begin(logic [31:0] ts);
    pn = 0; cur_ts = ts; pw[pn] = ts; pn++;
    first_ev = 1'b1;
  endtask

  // header {op, 16'h0, argc}; args a0, a1, then filler
  task automatic pk_op(logic [7:0] op, int argc, logic [31:0] a0, logic [31:0] a1);
    logic [31:0] e0, e1;
    bit rd, spi;
    pw[pn] = {op, 16'h0000, argc[7:0]}; pn++;
    for (int i = 0; i < argc; i++) begin
      pw[pn] = (i == 0) ? a0 : (i == 1) ? a1 : (32'hD00D_0000 + i); pn++;
    end
    e0 = (argc > 0) ? a0 : 32'd0;
    e1 = (argc > 1) ? a1 : 32'd0;
    rd  = (op == 8'h03) || (op == 8'h05);
    spi = (op == 8'h04) || (op == 8'h05);
    if (op == 8'h01) add_ev(0, {16'h0, e0[15:0]}, e1, 1'b0, 1'b0);
    else if (op >= 8'h02 && op <= 8'h05) begin
      add_ev(1, e0, rd ? 32'd0 : e1, spi, rd);
      if (rd) add_ev(2, 32'd0, {op, resp_fn(e0)}, 1'b0, 1'b0);
    end
  endtask

  task automatic send_word(logic [31:0] w, logic l);
    @(negedge clk);
    in_valid = 1'b1; in_data = w; in_last = l;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic pk_send();
    for (int i = 0; i < pn; i++) send_word(pw[i], i == pn - 1);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    nx_exact = 0; nx_frame = 0; nx_lim_en = 0; nx_r9 = 0;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while ((exp_q.size() != 0 || !in_ready) && t < 3000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic load_now(logic [31:0] v);
    @(negedge clk); now_load = 1'b1; now_val = v;
    @(negedge clk); now_load = 1'b0;
  endtask

  task automatic take_event(int kind, logic [31:0] a, logic [31:0] d, logic spi, logic rd);
    ev_t e;
    logic [31:0] obs;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R10", "unexpected output kind", kind, 32'hFFFF_FFFF);
      return;
    end
    e = exp_q.pop_front();
    chk(e.kind == kind, "R10", "output order kind", kind, e.kind);
    if (e.kind != kind) return;
    obs = now_time - 32'd1;
    if (kind == 0) begin
      chk(a == e.a, e.r9 ? "R9" : "R4", "reg addr", a, e.a);
      chk(d == e.d, e.r9 ? "R9" : "R4", "reg data", d, e.d);
    end else if (kind == 1) begin
      chk(a == e.a, "R5", "serial addr", a, e.a);
      chk(d == e.d, "R5", "serial data", d, e.d);
      chk({spi, rd} == {e.spi, e.rd}, "R5", "serial kind", {30'd0, spi, rd}, {30'd0, e.spi, e.rd});
    end else begin
      chk(d == e.d, "R6", "reply word", d, e.d);
    end
    if (kind != 2) begin
      chk($signed(obs - e.ts) >= 0, "R3", "dispatch not early", obs, e.ts);
      if (e.exact) chk(obs == e.ts, e.frame ? "R2" : "R3", "dispatch edge", obs, e.ts);
      if (e.lim_en) chk($signed(e.lim - obs) >= 0, "R3", "past stamp immediate", obs, e.lim);
    end
  endtask

  // output monitor and reply sink
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        rpl_ready = ($urandom % 4) != 0;
        if (reg_wr_en) take_event(0, {16'h0, reg_addr}, reg_wdata, 1'b0, 1'b0);
        if (ser_req_valid && !prev_sv) take_event(1, ser_req_addr, ser_req_data, ser_req_spi, ser_req_rd);
        if (rpl_valid && rpl_ready) take_event(2, 32'd0, rpl_data, 1'b0, 1'b0);
        if ((ser_req_valid || rpl_valid) && in_ready) r8_bad++;
        prev_sv = ser_req_valid;
      end
    end
  end

  // serial engine model
  initial begin
    logic [31:0] ca;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (ser_req_valid) begin
        repeat ($urandom % 3) @(negedge clk);
        ser_req_ready = 1'b1; ca = ser_req_addr;
        @(negedge clk);
        ser_req_ready = 1'b0;
        repeat (1 + $urandom % 3) @(negedge clk);
        ser_done_data = resp_fn(ca); ser_done_valid = 1'b1;
        @(negedge clk);
        ser_done_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] t0;
    void'($urandom(32'd20240613));
    nx_exact = 0; nx_frame = 0; nx_lim_en = 0; nx_r9 = 0; nx_lim = 0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1", "in_ready in reset", {31'd0, in_ready}, 32'd1);
    chk({reg_wr_en, ser_req_valid, rpl_valid} == 3'b000, "R1", "outputs idle in reset",
        {29'd0, reg_wr_en, ser_req_valid, rpl_valid}, 32'd0);
    chk(err_sticky == 1'b0, "R1", "err clear in reset", {31'd0, err_sticky}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b1 && !reg_wr_en && !ser_req_valid && !rpl_valid, "R1",
        "idle after reset", {31'd0, in_ready}, 32'd1);

    // R2/R3: future stamp, exact edge; second op held behind it (R8)
    t0 = now_time;
    pk_begin(t0 + 32'd30);
    nx_exact = 1; nx_frame = 1;
    pk_op(8'h01, 2, 32'hABCD_0042, 32'hCAFE_F00D);
    pk_op(8'h04, 2, 32'h0000_0777, 32'h1357_9BDF);
    pk_send();
    chk($signed(now_time - (t0 + 32'd30)) >= 0, "R8", "input held until dispatch", now_time, t0 + 32'd30);
    drain();

    // R3: future stamp across wrap
    load_now(32'hFFFF_FFF0);
    pk_begin(32'h0000_0008);
    nx_exact = 1;
    pk_op(8'h01, 2, 32'h0000_1111, 32'h2222_3333);
    pk_send();
    drain();

    // R3: stamp in the past across wrap, read ops (R5, R6)
    load_now(32'h0000_0010);
    t0 = now_time;
    pk_begin(32'hFFFF_FFE0);
    nx_lim_en = 1; nx_lim = t0 + 32'd10;
    pk_op(8'h03, 1, 32'h0000_0050, 32'd0);
    pk_op(8'h02, 2, 32'h0000_0051, 32'h0000_00A5);
    pk_op(8'h05, 1, 32'h0012_3456, 32'd0);
    pk_send();
    drain();

    // R7: unknown opcode with header-like args is skipped
    chk(err_sticky == 1'b0, "R7", "err clear before unknown op", {31'd0, err_sticky}, 32'd0);
    pk_begin(now_time);
    pk_op(8'h7E, 3, 32'h0100_0002, 32'h0000_9999);
    pk_op(8'h01, 2, 32'h0000_00E1, 32'h0E0E_0E0E);
    pk_send();
    drain();
    chk(err_sticky == 1'b1, "R7", "err set after unknown op", {31'd0, err_sticky}, 32'd1);

    // R9: short and long argument lists, early in_last
    pk_begin(now_time);
    nx_r9 = 1;
    pk_op(8'h01, 1, 32'h0000_00B1, 32'hFFFF_FFFF);
    nx_r9 = 1;
    pk_op(8'h01, 4, 32'h0000_00B2, 32'h0000_B2B2);
    pk_send();
    drain();
    pk_begin(now_time);
    pw[pn] = {8'h01, 16'h0000, 8'd3}; pn++;
    pw[pn] = 32'h0000_00B3; pn++;
    nx_r9 = 1;
    add_ev(0, 32'h0000_00B3, 32'd0, 1'b0, 1'b0);
    pk_send();
    t0 = now_time;
    pk_begin(t0 + 32'd25);
    nx_exact = 1; nx_frame = 1;
    pk_op(8'h01, 2, 32'h0000_00B4, 32'h0000_B4B4);
    pk_send();
    drain();

    // random packets
    for (int p = 0; p < 40; p++) begin
      int nops;
      pk_begin(now_time + ($urandom % 60) - 32'd20);
      nops = 1 + $urandom % 4;
      for (int o = 0; o < nops; o++) begin
        logic [7:0] op;
        int need;
        op = 8'(1 + $urandom % 5);
        need = (op == 8'h03 || op == 8'h05) ? 1 : 2;
        pk_op(op, need + ($urandom % 2), $urandom, $urandom);
      end
      pk_send();
    end
    drain();

    chk(r8_bad == 0, "R8", "in_ready low during serial/reply", r8_bad, 32'd0);
    chk(exp_q.size() == 0, "R10", "all expected outputs seen", exp_q.size(), 32'd0);
    chk(err_sticky == 1'b1, "R7", "err still set at end", {31'd0, err_sticky}, 32'd1);
    summary();
    $finish;
  end
endmodule